// File: doc/BRIEF.md
# CAN Controller Power-Save Sequencer

This block sequences the low-power state of a CAN controller. The CPU writes a two-bit power-save field. A value of 01 puts the controller to sleep. In sleep the protocol core clock is gated off, message-buffer access is withdrawn and register traffic is filtered. The block leaves sleep in one of two ways: the CPU writes 00 to the field, or a recessive-to-dominant edge appears on the receive pin. After either release the controller keeps the operating mode it had before sleep. It then waits for the bus to go idle before it rejoins.

The sequencer has three named states:
- RUN: awake and joined to the bus.
- SLEEP: clock gated.
- REJOIN: awake and counting recessive bits.

Its transitions are:
- RUN→SLEEP and REJOIN→SLEEP, on a write of 01.
- SLEEP→REJOIN, on a bus edge (bus wake) or on a write of 00 (CPU wake).
- REJOIN→RUN, when eleven recessive bits in a row have been counted (idle found).

The receive pin is taken in through a two-flop synchronizer. Recessive bits are counted on a bit-rate strobe, and any dominant sample restarts the count. An external clock-available input models the case where the controller clock has been switched off. While that input is low, bus edges cannot wake the block.

Top module: `can_sleep_ctrl`

## Requirements
- R1: After reset the block is in RUN with `psm_field`=00, `op_mode`=00, `core_clk_en`=1, `bus_on`=1 and `wake_status`=0. A write of 01 to the power-save field while in RUN or REJOIN enters SLEEP at the next rising edge. SLEEP shows `psm_field`=01, `core_clk_en`=0 and `bus_on`=0.
- R2: A write of 00 while in SLEEP moves to REJOIN at the next edge. REJOIN shows `psm_field`=00, `core_clk_en`=1 and `bus_on`=0, and this CPU wake leaves `wake_status` unchanged.
- R3: In SLEEP with `clk_avail`=1, a change of `rx_pin` from 1 to 0 moves the block to REJOIN at the third rising edge after the pin change. If a bus edge and a write of 00 arrive in the same cycle, the bus wake takes priority.
- R4: While `clk_avail`=0, the synchronizer holds its value and bus edges do not end sleep, so `psm_field` stays 01.
- R5: In SLEEP, `reg_wr_ok`=0 for every address. A power-save write of 10 or 11 and a `wake_clr` pulse have no effect.
- R6: In SLEEP, `reg_rd_ok`=0 for the pointer addresses 0x0A, 0x0C, 0x0E and 0x10, and 1 for every other address. Awake, `reg_rd_ok`=1 for all addresses.
- R7: Mode writes made in SLEEP are discarded, including 00, which is the initialization request. After wake, `op_mode` equals its value before sleep.
- R8: A bus wake sets `wake_status` to 1 whatever the value of `wake_ie`. The output `wake_irq` is high exactly when both `wake_status` and `wake_ie` are high. A `wake_clr` pulse while awake clears the status at the next edge.
- R9: After a wake, `bus_on` stays 0 until eleven consecutive `bit_tick` samples of the synchronized pin have read recessive (1). A dominant sample restarts the count. `bus_on` rises at the edge of the eleventh sample. The frame whose start bit woke the block is therefore never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_avail | input | 1 | 1 while the controller clock source is supplied |
| bit_tick | input | 1 | One-cycle strobe at the CAN bit sample point |
| rx_pin | input | 1 | CAN receive pin, 1 = recessive |
| psm_wr | input | 1 | CPU write strobe for the power-save field |
| psm_wdata | input | 2 | Power-save value written |
| mode_wr | input | 1 | CPU write strobe for the operating mode |
| mode_wdata | input | 2 | Operating mode written, 00 = initialization |
| wake_ie | input | 1 | Wake interrupt enable |
| wake_clr | input | 1 | Clears the wake status flag |
| reg_addr | input | ADDR_W | Address of the current register access |
| psm_field | output | 2 | Power-save field readback |
| op_mode | output | 2 | Current operating mode |
| core_clk_en | output | 1 | Clock-gate enable for the protocol core |
| bus_on | output | 1 | Buffer access and frame acceptance allowed |
| wake_status | output | 1 | Bus wake flag |
| wake_irq | output | 1 | Wake interrupt request |
| reg_wr_ok | output | 1 | Register write permitted |
| reg_rd_ok | output | 1 | Register read permitted at `reg_addr` |

## Verification
CPU writes to the power-save field take effect at the first rising edge after the strobe. A pin edge has three register stages to pass, so a bus wake shows up at the third edge. `bus_on` rises at the edge that samples the eleventh recessive strobe. The read and write filters follow the state and `reg_addr` with no delay. The bench drives inputs shortly after each falling edge and updates a behavioural model on each rising edge. It compares every output at the following falling edge, so each result is sampled exactly one edge after the cycle it is due in. Directed checks at the bus-wake edge confirm the three-edge latency by observing that the field is still 01 after the second edge.

// File: rtl/can_sleep_pkg.sv
package can_sleep_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'b00,
        PS_SLEEP  = 2'b01,
        PS_REJOIN = 2'b10
    } ps_state_t;

    localparam logic [1:0] PSM_AWAKE = 2'b00;
    localparam logic [1:0] PSM_SLEEP = 2'b01;
    localparam logic [1:0] OPM_INIT  = 2'b00;

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rx,
    output logic rx_level,
    output logic rx_fall
);

    logic meta_q, sync_q, prev_q;

    // Held frozen when the clock source is absent; reset to recessive.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else if (en) begin
            meta_q <= rx;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rx_level = sync_q;
    assign rx_fall  = prev_q & ~sync_q;

endmodule

// File: rtl/idle_bit_counter.sv
module idle_bit_counter #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bit_tick,
    input  logic rx_level,
    output logic idle_done
);

    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign idle_done = en && bit_tick && rx_level && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            if (!rx_level || cnt_q == LAST)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/reg_access_filter.sv
module reg_access_filter #(
    parameter int ADDR_W = 6,
    parameter int N_PTR  = 4,
    parameter logic [N_PTR*ADDR_W-1:0] PTR_LIST = '0
) (
    input  logic              asleep,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_ok,
    output logic              rd_ok
);

    logic [N_PTR-1:0] hit;

    for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
        assign hit[i] = (addr == PTR_LIST[i*ADDR_W +: ADDR_W]);
    end

    assign wr_ok = ~asleep;
    assign rd_ok = ~(asleep & (|hit));

endmodule

// File: rtl/can_sleep_ctrl.sv
module can_sleep_ctrl
    import can_sleep_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int IDLE_BITS = 11,
    parameter int N_PTR     = 4,
    parameter logic [N_PTR*ADDR_W-1:0] PTR_LIST = {6'h10, 6'h0E, 6'h0C, 6'h0A}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_avail,
    input  logic              bit_tick,
    input  logic              rx_pin,
    input  logic              psm_wr,
    input  logic [1:0]        psm_wdata,
    input  logic              mode_wr,
    input  logic [1:0]        mode_wdata,
    input  logic              wake_ie,
    input  logic              wake_clr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [1:0]        psm_field,
    output logic [1:0]        op_mode,
    output logic              core_clk_en,
    output logic              bus_on,
    output logic              wake_status,
    output logic              wake_irq,
    output logic              reg_wr_ok,
    output logic              reg_rd_ok
);

    ps_state_t state_q, state_d;
    logic rx_level, rx_fall, idle_done;
    logic sleep_req, cpu_wake, bus_wake, asleep;
    logic [1:0] mode_q;
    logic       flag_q;

    rx_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_avail),
        .rx       (rx_pin),
        .rx_level (rx_level),
        .rx_fall  (rx_fall)
    );

    idle_bit_counter #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (state_q == PS_REJOIN),
        .bit_tick  (bit_tick),
        .rx_level  (rx_level),
        .idle_done (idle_done)
    );

    reg_access_filter #(
        .ADDR_W   (ADDR_W),
        .N_PTR    (N_PTR),
        .PTR_LIST (PTR_LIST)
    ) u_filt (
        .asleep (asleep),
        .addr   (reg_addr),
        .wr_ok  (reg_wr_ok),
        .rd_ok  (reg_rd_ok)
    );

    assign sleep_req = psm_wr && (psm_wdata == PSM_SLEEP);
    assign cpu_wake  = psm_wr && (psm_wdata == PSM_AWAKE);
    assign bus_wake  = clk_avail && rx_fall;

    // Next-state logic; bus wake outranks CPU wake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN: begin
                if (sleep_req) state_d = PS_SLEEP;
            end
            PS_REJOIN: begin
                if (sleep_req)      state_d = PS_SLEEP;
                else if (idle_done) state_d = PS_RUN;
            end
            PS_SLEEP: begin
                if (bus_wake || cpu_wake) state_d = PS_REJOIN;
            end
            default: state_d = PS_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // Mode and wake flag: writable only while awake.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= OPM_INIT;
            flag_q <= 1'b0;
        end else if (state_q == PS_SLEEP) begin
            if (bus_wake) flag_q <= 1'b1;
        end else begin
            if (mode_wr)  mode_q <= mode_wdata;
            if (wake_clr) flag_q <= 1'b0;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        asleep      = (state_q == PS_SLEEP);
        psm_field   = asleep ? PSM_SLEEP : PSM_AWAKE;
        core_clk_en = ~asleep;
        bus_on      = (state_q == PS_RUN);
        op_mode     = mode_q;
        wake_status = flag_q;
        wake_irq    = flag_q & wake_ie;
    end

endmodule

// File: rtl/can_sleep_chk.sv
module can_sleep_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_avail,
    input logic       bit_tick,
    input logic       psm_wr,
    input logic [1:0] psm_wdata,
    input logic       wake_clr,
    input logic [1:0] psm_field,
    input logic [1:0] op_mode,
    input logic       core_clk_en,
    input logic       bus_on,
    input logic       wake_status,
    input logic       reg_wr_ok
);

    assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (psm_field != 2'b01 && psm_wr && psm_wdata == 2'b01)
        |=> (psm_field == 2'b01 && !core_clk_en && !bus_on));

    assert_cpu_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (psm_field == 2'b01 && psm_wr && psm_wdata == 2'b00)
        |=> (psm_field == 2'b00 && core_clk_en && !bus_on));

    assert_no_clock_no_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (psm_field == 2'b01 && !clk_avail && !(psm_wr && psm_wdata == 2'b00))
        |=> psm_field == 2'b01);

    assert_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        psm_field == 2'b01 |-> !reg_wr_ok);

    assert_mode_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        psm_field == 2'b01 |=> $stable(op_mode));

    assert_flag_from_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_status) |-> $past(psm_field) == 2'b01);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_clr && psm_field != 2'b01) |=> !wake_status);

    assert_join_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_on) |-> $past(bit_tick));

endmodule

bind can_sleep_ctrl can_sleep_chk u_chk (.*);

// File: tb/sim_can_sleep_ctrl.sv
module sim_can_sleep_ctrl;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       clk_avail = 1'b1, bit_tick = 1'b0, rx_pin = 1'b1;
    logic       psm_wr = 1'b0, mode_wr = 1'b0, wake_ie = 1'b0, wake_clr = 1'b0;
    logic [1:0] psm_wdata = 2'b00, mode_wdata = 2'b00;
    logic [5:0] reg_addr = 6'h00;
    logic [1:0] psm_field, op_mode;
    logic       core_clk_en, bus_on, wake_status, wake_irq, reg_wr_ok, reg_rd_ok;

    can_sleep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .clk_avail(clk_avail), .bit_tick(bit_tick),
        .rx_pin(rx_pin), .psm_wr(psm_wr), .psm_wdata(psm_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .wake_ie(wake_ie),
        .wake_clr(wake_clr), .reg_addr(reg_addr), .psm_field(psm_field),
        .op_mode(op_mode), .core_clk_en(core_clk_en), .bus_on(bus_on),
        .wake_status(wake_status), .wake_irq(wake_irq),
        .reg_wr_ok(reg_wr_ok), .reg_rd_ok(reg_rd_ok)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_ptr(int a);
        return (a == 10 || a == 12 || a == 14 || a == 16);
    endfunction

    // Behavioural reference: 0 = awake on bus, 1 = asleep, 2 = waiting for idle
    int m_st = 0, m_mode = 0, m_flag = 0, m_run = 0;
    int pin_hist[$] = '{1, 1, 1};   // oldest first: edge-detect, synced, first stage

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_mode = 0; m_flag = 0; m_run = 0;
            pin_hist = '{1, 1, 1};
        end else begin
            int nxt;
            bit dropped;
            nxt = m_st;
            dropped = (pin_hist[0] == 1) && (pin_hist[1] == 0);
            if (m_st != 2) m_run = 0;
            if (m_st == 1) begin
                if ((clk_avail && dropped) || (psm_wr && psm_wdata == 2'b00)) nxt = 2;
                if (clk_avail && dropped) m_flag = 1;
            end else begin
                if (mode_wr) m_mode = mode_wdata;
                if (wake_clr) m_flag = 0;
                if (psm_wr && psm_wdata == 2'b01) nxt = 1;
                else if (m_st == 2 && bit_tick) begin
                    if (pin_hist[1] == 0) m_run = 0;
                    else begin
                        m_run++;
                        if (m_run == 11) begin m_run = 0; nxt = 0; end
                    end
                end
            end
            m_st = nxt;
            if (clk_avail) begin
                void'(pin_hist.pop_front());
                pin_hist.push_back(int'(rx_pin));
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R1 psm_field", psm_field, (m_st == 1) ? 1 : 0);
            chk("R1 core_clk_en", core_clk_en, (m_st != 1) ? 1 : 0);
            chk("R9 bus_on", bus_on, (m_st == 0) ? 1 : 0);
            chk("R7 op_mode", op_mode, m_mode);
            chk("R8 wake_status", wake_status, m_flag);
            chk("R8 wake_irq", wake_irq, (m_flag != 0 && wake_ie) ? 1 : 0);
            chk("R5 reg_wr_ok", reg_wr_ok, (m_st != 1) ? 1 : 0);
            chk("R6 reg_rd_ok", reg_rd_ok, (m_st == 1 && is_ptr(int'(reg_addr))) ? 0 : 1);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic psm_write(logic [1:0] v);
        psm_wr = 1'b1; psm_wdata = v; step(); psm_wr = 1'b0;
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            bit_tick = 1'b1; step(); bit_tick = 1'b0; step(2);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        step(2);
        chk("R1 reset psm_field", psm_field, 0);
        chk("R1 reset bus_on", bus_on, 1);
        chk("R1 reset core_clk_en", core_clk_en, 1);
        chk("R1 reset op_mode", op_mode, 0);
        chk("R1 reset wake_status", wake_status, 0);
        rst_n = 1'b1; cmp_on = 1'b1; step();

        mode_wr = 1'b1; mode_wdata = 2'b01; step(); mode_wr = 1'b0;
        psm_write(2'b01); step();
        chk("R1 asleep", psm_field, 1);
        mode_wr = 1'b1; mode_wdata = 2'b00; step(); mode_wr = 1'b0;
        psm_write(2'b10); psm_write(2'b11);
        wake_clr = 1'b1; step(); wake_clr = 1'b0;
        chk("R7 init request ignored", op_mode, 1);
        chk("R5 reserved write ignored", psm_field, 1);
        for (int a = 0; a < 20; a++) begin reg_addr = 6'(a); step(); end

        psm_write(2'b00); step();
        chk("R2 cpu wake field", psm_field, 0);
        chk("R2 cpu wake no flag", wake_status, 0);
        chk("R7 mode restored", op_mode, 1);
        ticks(6); rx_pin = 1'b0; step(3); ticks(1); rx_pin = 1'b1; step(3);
        ticks(10);
        chk("R9 not yet joined", bus_on, 0);
        ticks(1);
        chk("R9 joined after 11", bus_on, 1);

        psm_write(2'b01); step(2);
        rx_pin = 1'b0; step(2);
        chk("R3 still asleep after two edges", psm_field, 1);
        step();
        chk("R3 bus wake at third edge", psm_field, 0);
        chk("R8 flag with ie low", wake_status, 1);
        chk("R8 irq masked", wake_irq, 0);
        wake_ie = 1'b1; step();
        chk("R8 irq enabled", wake_irq, 1);
        wake_clr = 1'b1; step(); wake_clr = 1'b0;
        chk("R8 flag cleared", wake_status, 0);
        rx_pin = 1'b1; step(3); ticks(11);

        psm_write(2'b01); step(2);
        clk_avail = 1'b0; step(); rx_pin = 1'b0; step(5);
        rx_pin = 1'b1; step(); rx_pin = 1'b0; step(3);
        chk("R4 no wake without clock", psm_field, 1);
        clk_avail = 1'b1; step(4);
        chk("R4 wake once clock back", psm_field, 0);
        chk("R3 flag after clock back", wake_status, 1);
        wake_clr = 1'b1; step(); wake_clr = 1'b0;
        rx_pin = 1'b1; step(3); ticks(11);

        psm_write(2'b01); step(2);
        rx_pin = 1'b0; step(2);
        psm_write(2'b00);
        chk("R3 bus wake wins tie", wake_status, 1);
        rx_pin = 1'b1; step(3); ticks(11);
        chk("R9 rejoined", bus_on, 1);

        finish_run();
    end

endmodule